// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block is the digital divider for a frequency synthesizer loop. It counts qualified input pulses, `fin_pulse`, and emits one output pulse per programmed division ratio. In direct mode every input pulse is one oscillator cycle, and the block divides by N. This mode suits the medium-wave band: for example, a 1260 kHz station with a +450 kHz IF puts the oscillator at 1710 kHz, and a 9 kHz reference then needs N = 190. In pulse-swallow mode every input pulse is one output of an external dual-modulus prescaler with a base modulus of 32. The block drives `mod_hi` to pick modulus 33 for the first A prescaler pulses of a cycle and modulus 32 for the rest, and it ends the cycle after M prescaler pulses. The oscillator is therefore divided by 32·M + A.

A second divider, clocked by the 7.2 MHz system clock, produces the comparison pulse. Its ratio comes from a 4-bit select code that indexes a table built when the design is elaborated. Both pulses go to the phase comparator. New settings are taken only at a terminal count, so a cycle is never cut short or stretched.

The oscillator divider is a state machine with four states:
- LOAD: the first cycle after reset. It loads the counters and leaves unconditionally.
- DIRECT: counts N input pulses.
- SWALLOW: modulus 33 is active. It goes to MAIN once the A-th pulse is counted, or it reaches the terminal count itself when A equals M.
- MAIN: modulus 32 is active. It counts the remaining pulses.

At every terminal count the machine reloads and picks DIRECT, SWALLOW (when A is not zero) or MAIN (when A is zero) from the live settings. The reference divider has two states, RLOAD and RCOUNT. RCOUNT reloads itself at each terminal count.

Top module: `psd_synth_divider`

## Requirements
- R1: While reset is held, and right after it is released in direct mode, `vco_div_pulse`, `ref_div_pulse` and `mod_hi` are all low.
- R2: With `swallow_mode`=0 the block gives one `vco_div_pulse` per `div_n` input pulses. A `div_n` of 0 or 1 acts as 2.
- R3: With `swallow_mode`=1 the block gives one `vco_div_pulse` per M input pulses, where M is `div_m` after the adjustment in R5.
- R4: In pulse-swallow mode `mod_hi` is high for the first `div_a` input pulses of each output cycle and low for the rest. With `div_a`=0, or in direct mode, it stays low.
- R5: A `div_m` smaller than `div_a` is raised to `div_a`. If both are zero, M becomes 1.
- R6: Changes to `swallow_mode`, `div_n`, `div_m` or `div_a` take effect only at the next terminal count of the oscillator divider.
- R7: Each `vco_div_pulse` is exactly one clock wide. It is high in the cycle right after the clock edge that samples the terminal `fin_pulse`.
- R8: The spacing of `ref_div_pulse`, in clocks, is set by `ref_sel`: 0→7200, 1→5760, 2→2880, 3→2400, 4→1440, 5→1152, 6→800, 7→720, 8→576, 9→288, 10→144. Codes 11 to 15 give 7200. Each pulse is one clock wide.
- R9: A new `ref_sel` takes effect only at the next reference terminal count. The interval already running keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (7.2 MHz assumed for the reference table) |
| rst_n | input | 1 | Asynchronous active-low reset |
| fin_pulse | input | 1 | One-clock qualified pulse per oscillator cycle (direct) or per prescaler output (swallow) |
| swallow_mode | input | 1 | 0 = direct division, 1 = pulse-swallow division |
| div_n | input | 16 | Direct division ratio N |
| div_m | input | 12 | Main counter value M |
| div_a | input | 5 | Swallow counter value A (always below the prescaler base of 32) |
| ref_sel | input | 4 | Reference frequency select code |
| mod_hi | output | 1 | Prescaler modulus control: 1 selects 33, 0 selects 32 |
| vco_div_pulse | output | 1 | Divided oscillator pulse to the phase comparator |
| ref_div_pulse | output | 1 | Divided reference pulse to the phase comparator |

## Verification
`vco_div_pulse` is due one clock after the edge that samples the terminal `fin_pulse`. The driver counts the input pulses it issues, and when its own model reaches a terminal count it queues that pulse index. The monitor samples on falling edges and compares the queued index with the running pulse count, which has not yet advanced when the output is seen, because every input pulse is followed by at least one low cycle. `mod_hi` is a state output that must be settled before each pulse is raised, so the driver checks it on the falling edge where it raises `fin_pulse`. Reference spacing is measured edge to edge. The expected interval is re-read from `ref_sel` only when a pulse is seen, and the select code is changed a few cycles after a pulse, so a new code is due one full interval later.

// File: rtl/psd_pkg.sv
package psd_pkg;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_DIRECT,
        ST_SWALLOW,
        ST_MAIN
    } vco_state_t;

    typedef enum logic {
        RS_LOAD,
        RS_COUNT
    } ref_state_t;

    localparam int unsigned REF_CODES = 16;

    // Comparison frequency of each select code, in quarter-kHz units.
    function automatic int unsigned ref_quarter_khz(input int unsigned code);
        case (code)
            0:       return 4;
            1:       return 5;
            2:       return 10;
            3:       return 12;
            4:       return 20;
            5:       return 25;
            6:       return 36;
            7:       return 40;
            8:       return 50;
            9:       return 100;
            10:      return 200;
            default: return 4;
        endcase
    endfunction

    function automatic int unsigned ref_divisor(input int unsigned clk_khz,
                                                input int unsigned code);
        return (clk_khz * 4) / ref_quarter_khz(code);
    endfunction

endpackage

// File: rtl/psd_ref_div.sv
module psd_ref_div
    import psd_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 7200,
    parameter int unsigned REF_W   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] sel,
    output logic       tick
);

    logic [REF_W-1:0] div_tab [REF_CODES];

    for (genvar g = 0; g < REF_CODES; g++) begin : g_tab
        localparam int unsigned DIVV = ref_divisor(CLK_KHZ, g);
        assign div_tab[g] = REF_W'(DIVV);
    end

    ref_state_t       st_q, st_d;
    logic [REF_W-1:0] cnt_q, cnt_d;
    logic             hit;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        hit   = 1'b0;
        unique case (st_q)
            RS_LOAD: begin
                cnt_d = div_tab[sel];
                st_d  = RS_COUNT;
            end
            RS_COUNT: begin
                if (cnt_q == REF_W'(1)) begin
                    hit   = 1'b1;
                    cnt_d = div_tab[sel];
                end else begin
                    cnt_d = cnt_q - REF_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RS_LOAD;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick <= 1'b0;
        end else begin
            tick <= hit;
        end
    end

endmodule

// File: rtl/psd_cfg_clamp.sv
module psd_cfg_clamp #(
    parameter int unsigned N_W = 16,
    parameter int unsigned M_W = 12,
    parameter int unsigned A_W = 5
) (
    input  logic [N_W-1:0] n_raw,
    input  logic [M_W-1:0] m_raw,
    input  logic [A_W-1:0] a_raw,
    output logic [N_W-1:0] n_eff,
    output logic [M_W-1:0] m_eff,
    output logic [A_W-1:0] a_eff
);

    logic [M_W-1:0] a_wide;
    logic [M_W-1:0] m_raised;

    assign a_wide = M_W'(a_raw);
    assign a_eff  = a_raw;

    always_comb begin
        n_eff = (n_raw < N_W'(2)) ? N_W'(2) : n_raw;
    end

    always_comb begin
        m_raised = (m_raw < a_wide) ? a_wide : m_raw;
        m_eff    = (m_raised == '0) ? M_W'(1) : m_raised;
    end

endmodule

// File: rtl/psd_vco_div.sv
module psd_vco_div
    import psd_pkg::*;
#(
    parameter int unsigned N_W = 16,
    parameter int unsigned M_W = 12,
    parameter int unsigned A_W = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fin_pulse,
    input  logic           swallow_mode,
    input  logic [N_W-1:0] n_eff,
    input  logic [M_W-1:0] m_eff,
    input  logic [A_W-1:0] a_eff,
    output logic           mod_hi,
    output logic           div_tick,
    output logic           loading
);

    vco_state_t     st_q, st_d;
    logic [N_W-1:0] cnt_q, cnt_d;
    logic [A_W-1:0] acnt_q, acnt_d;
    logic           term;

    vco_state_t     ld_state;
    logic [N_W-1:0] ld_cnt;

    always_comb begin
        if (swallow_mode) begin
            ld_state = (a_eff != '0) ? ST_SWALLOW : ST_MAIN;
            ld_cnt   = N_W'(m_eff);
        end else begin
            ld_state = ST_DIRECT;
            ld_cnt   = n_eff;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        acnt_d = acnt_q;
        term   = 1'b0;
        unique case (st_q)
            ST_LOAD: begin
                st_d   = ld_state;
                cnt_d  = ld_cnt;
                acnt_d = a_eff;
            end
            ST_DIRECT, ST_MAIN: begin
                if (fin_pulse) begin
                    if (cnt_q == N_W'(1)) begin
                        term   = 1'b1;
                        st_d   = ld_state;
                        cnt_d  = ld_cnt;
                        acnt_d = a_eff;
                    end else begin
                        cnt_d = cnt_q - N_W'(1);
                    end
                end
            end
            ST_SWALLOW: begin
                if (fin_pulse) begin
                    if (cnt_q == N_W'(1)) begin
                        term   = 1'b1;
                        st_d   = ld_state;
                        cnt_d  = ld_cnt;
                        acnt_d = a_eff;
                    end else begin
                        cnt_d  = cnt_q - N_W'(1);
                        acnt_d = acnt_q - A_W'(1);
                        if (acnt_q == A_W'(1)) begin
                            st_d = ST_MAIN;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_LOAD;
            cnt_q  <= '0;
            acnt_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            acnt_q <= acnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_tick <= 1'b0;
        end else begin
            div_tick <= term;
        end
    end

    assign mod_hi  = (st_q == ST_SWALLOW);
    assign loading = (st_q == ST_LOAD);

endmodule

// File: rtl/psd_synth_divider.sv
module psd_synth_divider #(
    parameter int unsigned PRESCALE = 32,
    parameter int unsigned N_W      = 16,
    parameter int unsigned M_W      = 12,
    parameter int unsigned CLK_KHZ  = 7200,
    parameter int unsigned REF_W    = 16,
    localparam int unsigned A_W     = $clog2(PRESCALE)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fin_pulse,
    input  logic           swallow_mode,
    input  logic [N_W-1:0] div_n,
    input  logic [M_W-1:0] div_m,
    input  logic [A_W-1:0] div_a,
    input  logic [3:0]     ref_sel,
    output logic           mod_hi,
    output logic           vco_div_pulse,
    output logic           ref_div_pulse
);

    logic [N_W-1:0] n_eff;
    logic [M_W-1:0] m_eff;
    logic [A_W-1:0] a_eff;
    logic           vco_loading;

    psd_cfg_clamp #(
        .N_W(N_W),
        .M_W(M_W),
        .A_W(A_W)
    ) u_clamp (
        .n_raw(div_n),
        .m_raw(div_m),
        .a_raw(div_a),
        .n_eff(n_eff),
        .m_eff(m_eff),
        .a_eff(a_eff)
    );

    psd_vco_div #(
        .N_W(N_W),
        .M_W(M_W),
        .A_W(A_W)
    ) u_vco (
        .clk(clk),
        .rst_n(rst_n),
        .fin_pulse(fin_pulse),
        .swallow_mode(swallow_mode),
        .n_eff(n_eff),
        .m_eff(m_eff),
        .a_eff(a_eff),
        .mod_hi(mod_hi),
        .div_tick(vco_div_pulse),
        .loading(vco_loading)
    );

    psd_ref_div #(
        .CLK_KHZ(CLK_KHZ),
        .REF_W(REF_W)
    ) u_ref (
        .clk(clk),
        .rst_n(rst_n),
        .sel(ref_sel),
        .tick(ref_div_pulse)
    );

endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
    parameter int unsigned MIN_REF = 144,
    parameter int unsigned GAP_W   = 16
) (
    input logic clk,
    input logic rst_n,
    input logic fin_pulse,
    input logic mod_hi,
    input logic vco_div_pulse,
    input logic ref_div_pulse,
    input logic loading
);

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (ref_div_pulse) begin
            gap_q <= '0;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    // R7: output pulse lasts exactly one clock
    a_r7_vco_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        vco_div_pulse |=> !vco_div_pulse);

    // R7: output pulse follows a sampled input pulse
    a_r7_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        vco_div_pulse |-> $past(fin_pulse));

    // R4: modulus control only moves on an input pulse once loaded
    a_r4_mod_hi_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!loading && !fin_pulse) |=> $stable(mod_hi));

    // R8: reference pulse lasts exactly one clock
    a_r8_ref_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ref_div_pulse |=> !ref_div_pulse);

    // R8: reference pulses are never closer than the smallest table entry
    a_r8_ref_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ref_div_pulse |-> (gap_q >= GAP_W'(MIN_REF - 1)));

endmodule

bind psd_synth_divider psd_checker #(
    .MIN_REF(144),
    .GAP_W(16)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .fin_pulse(fin_pulse),
    .mod_hi(mod_hi),
    .vco_div_pulse(vco_div_pulse),
    .ref_div_pulse(ref_div_pulse),
    .loading(vco_loading)
);

// File: tb/psd_synth_divider_test.sv
module psd_synth_divider_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fin_pulse = 1'b0;
    logic        swallow_mode = 1'b0;
    logic [15:0] div_n = 16'd190;
    logic [11:0] div_m = 12'd40;
    logic [4:0]  div_a = 5'd5;
    logic [3:0]  ref_sel = 4'd10;
    logic        mod_hi, vco_div_pulse, ref_div_pulse;

    psd_synth_divider uut (
        .clk(clk), .rst_n(rst_n), .fin_pulse(fin_pulse),
        .swallow_mode(swallow_mode), .div_n(div_n), .div_m(div_m),
        .div_a(div_a), .ref_sel(ref_sel), .mod_hi(mod_hi),
        .vco_div_pulse(vco_div_pulse), .ref_div_pulse(ref_div_pulse)
    );

    always #5 clk = ~clk;

    int    n_chk = 0, n_err = 0;
    int    cyc = 0;
    int    fin_total = 0;
    int    k = 0, per_cur = 0, a_cur = 0;
    bit    sw_cur = 0;
    int    exp_q[$];
    string vco_tag = "R2";
    string ref_tag = "R8";
    int    ref_last = -1, ref_exp = 0;
    bit    prev_vco = 0, prev_ref = 0, done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int ref_tab(input int code);
        case (code)
            0: return 7200;  1: return 5760; 2: return 2880; 3: return 2400;
            4: return 1440;  5: return 1152; 6: return 800;  7: return 720;
            8: return 576;   9: return 288;  10: return 144;
            default: return 7200;
        endcase
    endfunction

    // Model: settings read at each terminal count (R6)
    task automatic take_config();
        int m, a;
        if (swallow_mode) begin
            a = int'(div_a);
            m = int'(div_m);
            if (m < a) m = a;          // R5
            if (m == 0) m = 1;         // R5
            per_cur = m; a_cur = a; sw_cur = 1;
        end else begin
            per_cur = (div_n < 2) ? 2 : int'(div_n);   // R2
            a_cur = 0; sw_cur = 0;
        end
    endtask

    task automatic pulse(input int gap);
        bit exp_hi;
        @(negedge clk);
        exp_hi = sw_cur && (k < a_cur);
        check(mod_hi == exp_hi, "R4 mod_hi", int'(mod_hi), int'(exp_hi));
        fin_pulse = 1'b1;
        fin_total++;
        k++;
        if (k == per_cur) begin
            exp_q.push_back(fin_total);
            k = 0;
            take_config();
        end
        @(negedge clk);
        fin_pulse = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    always @(posedge clk) cyc++;

    // Monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (vco_div_pulse) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, {vco_tag, " unexpected pulse"}, fin_total, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(fin_total == e, {vco_tag, " R7 pulse index"}, fin_total, e);
                end
                if (prev_vco) check(1'b0, "R7 width", 2, 1);
            end
            if (ref_div_pulse) begin
                if (prev_ref) check(1'b0, "R8 width", 2, 1);
                else begin
                    if (ref_last >= 0)
                        check(cyc - ref_last == ref_exp, ref_tag, cyc - ref_last, ref_exp);
                    ref_last = cyc;
                    ref_exp  = ref_tab(int'(ref_sel));
                end
            end
            prev_vco = vco_div_pulse;
            prev_ref = ref_div_pulse;
        end
    end

    task automatic change_ref(input int code, input string tag);
        @(negedge clk);
        while (!ref_div_pulse) @(negedge clk);
        repeat (5) @(negedge clk);
        ref_sel = 4'(code);
        ref_tag = tag;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(!vco_div_pulse && !ref_div_pulse && !mod_hi, "R1 reset outputs",
              int'({vco_div_pulse, ref_div_pulse, mod_hi}), 0);
        rst_n = 1'b1;
        take_config();
        repeat (2) @(negedge clk);
        check(!mod_hi && !vco_div_pulse, "R1 after release",
              int'({vco_div_pulse, mod_hi}), 0);

        // R2: direct division by 190 (1710 kHz / 9 kHz)
        vco_tag = "R2";
        repeat (380) pulse(1);
        // R2: ratio 1 acts as 2
        div_n = 16'd1;
        repeat (12) pulse(0);

        // R3 R4: swallow M=40 A=5
        vco_tag = "R3";
        swallow_mode = 1'b1; div_m = 12'd40; div_a = 5'd5;
        repeat (130) pulse(1);
        // R4: A=0 never high
        vco_tag = "R4";
        div_m = 12'd10; div_a = 5'd0;
        repeat (40) pulse(0);

        // R5: M below A, and both zero
        vco_tag = "R5";
        div_m = 12'd3; div_a = 5'd7;
        repeat (30) pulse(0);
        div_m = 12'd0; div_a = 5'd0;
        repeat (12) pulse(0);

        // R6: changes mid-cycle wait for terminal count
        vco_tag = "R6";
        div_m = 12'd20; div_a = 5'd3;
        repeat (7) pulse(1);
        div_m = 12'd12; div_a = 5'd9;
        repeat (60) pulse(0);
        repeat (5) pulse(0);
        swallow_mode = 1'b0; div_n = 16'd50;
        repeat (120) pulse(1);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R6 missing pulses", exp_q.size(), 0);

        // R9: reference select changes
        change_ref(6, "R9 to 800");
        repeat (2000) @(negedge clk);
        change_ref(15, "R8 code 15");
        repeat (15000) @(negedge clk);
        change_ref(3, "R9 to 2400");
        repeat (5000) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            check(1'b0, "watchdog", cyc, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule